// File: doc/BRIEF.md
# Coherence Cache Update Decision Logic

This block is the decision stage of a private-cache coherence controller. A request has already been looked up by set: the stage before it supplies, for every way of that set, the stored tag, the read and write privilege bits and the coherence state. The protocol table has already chosen the actions for the request. From these inputs the block finishes the lookup by comparing tags. It then decides whether a valid block must be evicted, and forms every update that follows from the request: one command to the load/store unit, one coherence-state write, one MSHR write, and one cache read for outgoing data.

The eviction of a victim is not started directly. The block pre-allocates an MSHR entry that holds the victim's address and state, with a waiting-for-eviction flag set. The issue stage later sees that flag and issues the eviction before any other request to the same block. All outputs leave through one register stage, so every result appears one clock after the request sits at the inputs.

Top module: `coh_update_logic`

## Requirements
- R1: A way hits when its tag equals `req_tag` and its read or write privilege is set. `tag_hit` is the OR over all ways, and `hit_way` is the binary index of the hitting way (0 when nothing hits).
- R2: Every output is registered once: it reflects the inputs of the previous clock. After reset all outputs are 0. In any cycle after a cycle with `req_valid` low, `ls_upd_valid`, `cs_wr_en`, `mshr_upd_en` and `snoop_valid` are 0.
- R3: The victim is valid when the LRU way has a read or write privilege. The victim address is {LRU way tag, `req_set`, all-zero offset}, with the tag in the most significant bits. The victim state is the LRU way's coherence state.
- R4: A replacement occurs when `act_write_data` is set, the tag lookup missed, and the victim is valid.
- R5: `ls_upd_cmd` is 2 on a replacement. Otherwise it is 1 when `act_write_data` is set, and 0 in every other case. The value 3 never appears.
- R6: The target way for both `ls_upd_way` and `cs_wr_way` is `hit_way` on a hit, and `lru_way` otherwise.
- R7: `ls_upd_valid` is set for a valid request when either `act_update_priv` is set and the lookup hit, or `act_write_data` is set.
- R8: `cs_wr_en` is set for a valid request when `act_next_stable` is set and either the lookup hit or `act_write_data` is set. `cs_wr_state` is `act_next_state` and `cs_wr_set` is `req_set`.
- R9: `mshr_upd_en` is set for a valid request when any MSHR allocate, update or deallocate action is set, or when a replacement occurs. `mshr_upd_idx` is `mshr_hit_idx` when `mshr_hit` is set, and `mshr_free_idx` otherwise.
- R10: On a replacement the MSHR entry holds the victim address and victim state, and `mshr_wait_evict` is 1. Otherwise the entry holds {`req_tag`, `req_set`, zero offset} and `act_next_state`, and `mshr_wait_evict` is 0.
- R11: `snoop_valid` is `req_valid` AND `act_send_data`. `snoop_set` is `req_set` and `snoop_way` is the hit way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | A request occupies this stage |
| req_tag | input | TAG_W | Request tag |
| req_set | input | SET_W | Request set index |
| act_write_data | input | 1 | Protocol: write a block into the cache |
| act_update_priv | input | 1 | Protocol: change privileges |
| act_next_state | input | STATE_W | Protocol: next coherence state |
| act_next_stable | input | 1 | Protocol: next state is stable |
| act_send_data | input | 1 | Protocol: send cached data out |
| act_mshr_alloc | input | 1 | Protocol: allocate MSHR entry |
| act_mshr_update | input | 1 | Protocol: update MSHR entry |
| act_mshr_dealloc | input | 1 | Protocol: free MSHR entry |
| way_tags | input | WAYS*TAG_W | Per-way tags, way 0 in the low bits |
| way_can_read | input | WAYS | Per-way read privilege |
| way_can_write | input | WAYS | Per-way write privilege |
| way_states | input | WAYS*STATE_W | Per-way coherence states, way 0 in the low bits |
| lru_way | input | log2(WAYS) | Least recently used way |
| mshr_hit | input | 1 | MSHR holds an entry for this block |
| mshr_hit_idx | input | log2(MSHR_N) | Index of that entry |
| mshr_free_idx | input | log2(MSHR_N) | Index of a free entry |
| tag_hit | output | 1 | Registered tag lookup hit |
| hit_way | output | log2(WAYS) | Registered hitting way |
| ls_upd_valid | output | 1 | Load/store update request |
| ls_upd_cmd | output | 2 | 0 info only, 1 info and data, 2 replacement |
| ls_upd_way | output | log2(WAYS) | Load/store update way |
| cs_wr_en | output | 1 | Coherence-state write enable |
| cs_wr_set | output | SET_W | Coherence-state write set |
| cs_wr_way | output | log2(WAYS) | Coherence-state write way |
| cs_wr_state | output | STATE_W | Coherence-state write value |
| mshr_upd_en | output | 1 | MSHR write enable |
| mshr_upd_idx | output | log2(MSHR_N) | MSHR entry to write |
| mshr_wait_evict | output | 1 | Entry is a pre-allocation for an eviction |
| mshr_entry_addr | output | TAG_W+SET_W+OFF_W | Entry block address |
| mshr_entry_state | output | STATE_W | Entry coherence state |
| snoop_valid | output | 1 | Read cached data for an outgoing message |
| snoop_set | output | SET_W | Set to read |
| snoop_way | output | log2(WAYS) | Way to read |

## Verification
Some relations are checked on every cycle. The enables stay quiet after an idle input cycle, and command value 3 never occurs. A replacement command always comes with a flagged MSHR pre-allocation on a lookup miss, and no replacement happens when the LRU way holds no privilege. A miss targets the LRU way, the two cache writes agree on the way, and the MSHR index follows the previous cycle's MSHR hit. Only the bench's scenarios can show the full decisions, which it compares with values it computes itself. These are the tag match that ignores a matching tag without privileges, the choice among the three commands, the victim address formed from the LRU tag, and the entry payload on and off a replacement.

// File: rtl/coh_update_logic.sv
module coh_update_logic #(
  parameter int WAYS    = 4,
  parameter int TAG_W   = 8,
  parameter int SET_W   = 4,
  parameter int OFF_W   = 4,
  parameter int STATE_W = 3,
  parameter int MSHR_N  = 4,
  localparam int WAY_W  = $clog2(WAYS),
  localparam int MIDX_W = $clog2(MSHR_N),
  localparam int ADDR_W = TAG_W + SET_W + OFF_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  input  logic [TAG_W-1:0]        req_tag,
  input  logic [SET_W-1:0]        req_set,
  input  logic                    act_write_data,
  input  logic                    act_update_priv,
  input  logic [STATE_W-1:0]      act_next_state,
  input  logic                    act_next_stable,
  input  logic                    act_send_data,
  input  logic                    act_mshr_alloc,
  input  logic                    act_mshr_update,
  input  logic                    act_mshr_dealloc,
  input  logic [WAYS*TAG_W-1:0]   way_tags,
  input  logic [WAYS-1:0]         way_can_read,
  input  logic [WAYS-1:0]         way_can_write,
  input  logic [WAYS*STATE_W-1:0] way_states,
  input  logic [WAY_W-1:0]        lru_way,
  input  logic                    mshr_hit,
  input  logic [MIDX_W-1:0]       mshr_hit_idx,
  input  logic [MIDX_W-1:0]       mshr_free_idx,
  output logic                    tag_hit,
  output logic [WAY_W-1:0]        hit_way,
  output logic                    ls_upd_valid,
  output logic [1:0]              ls_upd_cmd,
  output logic [WAY_W-1:0]        ls_upd_way,
  output logic                    cs_wr_en,
  output logic [SET_W-1:0]        cs_wr_set,
  output logic [WAY_W-1:0]        cs_wr_way,
  output logic [STATE_W-1:0]      cs_wr_state,
  output logic                    mshr_upd_en,
  output logic [MIDX_W-1:0]       mshr_upd_idx,
  output logic                    mshr_wait_evict,
  output logic [ADDR_W-1:0]       mshr_entry_addr,
  output logic [STATE_W-1:0]      mshr_entry_state,
  output logic                    snoop_valid,
  output logic [SET_W-1:0]        snoop_set,
  output logic [WAY_W-1:0]        snoop_way
);

  localparam logic [1:0] CMD_INFO      = 2'd0;
  localparam logic [1:0] CMD_INFO_DATA = 2'd1;
  localparam logic [1:0] CMD_REPLACE   = 2'd2;

  logic [WAYS-1:0]    hit_map;
  logic               hit_c;
  logic [WAY_W-1:0]   hit_way_c;
  logic               victim_ok;
  logic [ADDR_W-1:0]  victim_addr;
  logic [STATE_W-1:0] victim_state;
  logic               repl_c;
  logic [WAY_W-1:0]   tgt_way;
  logic [1:0]         cmd_c;

  genvar w;
  generate
    for (w = 0; w < WAYS; w++) begin : g_match
      assign hit_map[w] = (way_tags[w*TAG_W +: TAG_W] == req_tag) &&
                          (way_can_read[w] || way_can_write[w]);
    end
  endgenerate

  always_comb begin
    hit_way_c = '0;
    for (int i = 0; i < WAYS; i++)
      if (hit_map[i]) hit_way_c = hit_way_c | WAY_W'(i);
  end

  assign hit_c        = |hit_map;
  assign victim_ok    = way_can_read[lru_way] || way_can_write[lru_way];
  assign victim_addr  = {way_tags[lru_way*TAG_W +: TAG_W], req_set, {OFF_W{1'b0}}};
  assign victim_state = way_states[lru_way*STATE_W +: STATE_W];
  assign repl_c       = act_write_data && !hit_c && victim_ok;
  assign tgt_way      = hit_c ? hit_way_c : lru_way;
  assign cmd_c        = repl_c ? CMD_REPLACE : (act_write_data ? CMD_INFO_DATA : CMD_INFO);

  always_ff @(posedge clk) begin
    if (rst) begin
      tag_hit          <= 1'b0;
      hit_way          <= '0;
      ls_upd_valid     <= 1'b0;
      ls_upd_cmd       <= CMD_INFO;
      ls_upd_way       <= '0;
      cs_wr_en         <= 1'b0;
      cs_wr_set        <= '0;
      cs_wr_way        <= '0;
      cs_wr_state      <= '0;
      mshr_upd_en      <= 1'b0;
      mshr_upd_idx     <= '0;
      mshr_wait_evict  <= 1'b0;
      mshr_entry_addr  <= '0;
      mshr_entry_state <= '0;
      snoop_valid      <= 1'b0;
      snoop_set        <= '0;
      snoop_way        <= '0;
    end else begin
      tag_hit          <= hit_c;
      hit_way          <= hit_way_c;
      ls_upd_valid     <= req_valid && ((act_update_priv && hit_c) || act_write_data);
      ls_upd_cmd       <= cmd_c;
      ls_upd_way       <= tgt_way;
      cs_wr_en         <= req_valid && act_next_stable && (hit_c || act_write_data);
      cs_wr_set        <= req_set;
      cs_wr_way        <= tgt_way;
      cs_wr_state      <= act_next_state;
      mshr_upd_en      <= req_valid && (act_mshr_alloc || act_mshr_update ||
                                        act_mshr_dealloc || repl_c);
      mshr_upd_idx     <= mshr_hit ? mshr_hit_idx : mshr_free_idx;
      mshr_wait_evict  <= repl_c;
      mshr_entry_addr  <= repl_c ? victim_addr : {req_tag, req_set, {OFF_W{1'b0}}};
      mshr_entry_state <= repl_c ? victim_state : act_next_state;
      snoop_valid      <= req_valid && act_send_data;
      snoop_set        <= req_set;
      snoop_way        <= hit_way_c;
    end
  end

endmodule

// File: rtl/coh_update_logic_chk.sv
module coh_update_logic_chk #(
  parameter int WAYS    = 4,
  parameter int TAG_W   = 8,
  parameter int SET_W   = 4,
  parameter int OFF_W   = 4,
  parameter int STATE_W = 3,
  parameter int MSHR_N  = 4,
  localparam int WAY_W  = $clog2(WAYS),
  localparam int MIDX_W = $clog2(MSHR_N)
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              act_write_data,
  input logic [WAYS-1:0]   way_can_read,
  input logic [WAYS-1:0]   way_can_write,
  input logic [WAY_W-1:0]  lru_way,
  input logic              mshr_hit,
  input logic [MIDX_W-1:0] mshr_hit_idx,
  input logic [MIDX_W-1:0] mshr_free_idx,
  input logic              tag_hit,
  input logic              ls_upd_valid,
  input logic [1:0]        ls_upd_cmd,
  input logic [WAY_W-1:0]  ls_upd_way,
  input logic              cs_wr_en,
  input logic [WAY_W-1:0]  cs_wr_way,
  input logic              mshr_upd_en,
  input logic [MIDX_W-1:0] mshr_upd_idx,
  input logic              mshr_wait_evict,
  input logic              snoop_valid
);

  // R5
  cmd_code_chk: assert property (@(posedge clk) disable iff (rst)
    ls_upd_cmd != 2'd3);

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !ls_upd_valid && !cs_wr_en && !mshr_upd_en && !snoop_valid);

  // R4
  repl_prealloc_chk: assert property (@(posedge clk) disable iff (rst)
    (ls_upd_valid && ls_upd_cmd == 2'd2) |-> (mshr_upd_en && mshr_wait_evict && !tag_hit));

  // R3
  no_victim_no_repl_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && act_write_data && !way_can_read[lru_way] && !way_can_write[lru_way])
      |=> (ls_upd_cmd != 2'd2 && !mshr_wait_evict));

  // R6
  miss_way_chk: assert property (@(posedge clk) disable iff (rst)
    (ls_upd_valid && !tag_hit) |-> ls_upd_way == $past(lru_way));

  // R6
  way_agree_chk: assert property (@(posedge clk) disable iff (rst)
    (cs_wr_en && ls_upd_valid) |-> cs_wr_way == ls_upd_way);

  // R9
  mshr_idx_chk: assert property (@(posedge clk) disable iff (rst)
    mshr_upd_en |-> mshr_upd_idx == ($past(mshr_hit) ? $past(mshr_hit_idx) : $past(mshr_free_idx)));

endmodule

bind coh_update_logic coh_update_logic_chk #(
  .WAYS(WAYS), .TAG_W(TAG_W), .SET_W(SET_W), .OFF_W(OFF_W),
  .STATE_W(STATE_W), .MSHR_N(MSHR_N)
) chk_i (.*);

// File: tb/coh_update_logic_tb_top.sv
module coh_update_logic_tb_top;
  localparam int WAYS = 4, TAG_W = 8, SET_W = 4, OFF_W = 4, STATE_W = 3, MSHR_N = 4;
  localparam int WAY_W = 2, MIDX_W = 2, ADDR_W = TAG_W + SET_W + OFF_W;

  logic clk = 1'b0, rst = 1'b1;
  always #2.5 clk = ~clk;

  logic req_valid = 0, act_write_data = 0, act_update_priv = 0, act_next_stable = 0;
  logic act_send_data = 0, act_mshr_alloc = 0, act_mshr_update = 0, act_mshr_dealloc = 0;
  logic [TAG_W-1:0] req_tag = '0;
  logic [SET_W-1:0] req_set = '0;
  logic [STATE_W-1:0] act_next_state = '0;
  logic [TAG_W-1:0] tg [WAYS];
  logic [STATE_W-1:0] st [WAYS];
  logic [WAYS-1:0] way_can_read = '0, way_can_write = '0;
  logic [WAY_W-1:0] lru_way = '0;
  logic mshr_hit = 0;
  logic [MIDX_W-1:0] mshr_hit_idx = '0, mshr_free_idx = '0;
  logic [WAYS*TAG_W-1:0] way_tags;
  logic [WAYS*STATE_W-1:0] way_states;
  assign way_tags   = {tg[3], tg[2], tg[1], tg[0]};
  assign way_states = {st[3], st[2], st[1], st[0]};

  logic tag_hit, ls_upd_valid, cs_wr_en, mshr_upd_en, mshr_wait_evict, snoop_valid;
  logic [WAY_W-1:0] hit_way, ls_upd_way, cs_wr_way, snoop_way;
  logic [1:0] ls_upd_cmd;
  logic [SET_W-1:0] cs_wr_set, snoop_set;
  logic [STATE_W-1:0] cs_wr_state, mshr_entry_state;
  logic [MIDX_W-1:0] mshr_upd_idx;
  logic [ADDR_W-1:0] mshr_entry_addr;

  coh_update_logic dut_i (.*);

  int checks = 0, errors = 0;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    bit h = 0, vv, rp;
    int hw = 0, tw, cmd;
    for (int i = 0; i < WAYS; i++)
      if (tg[i] == req_tag && (way_can_read[i] || way_can_write[i])) begin h = 1; hw = i; end
    vv = way_can_read[lru_way] || way_can_write[lru_way];
    rp = act_write_data && !h && vv;
    tw = h ? hw : int'(lru_way);
    cmd = rp ? 2 : (act_write_data ? 1 : 0);
    @(posedge clk); #1;
    chk("R1 tag_hit", tag_hit, h);
    chk("R1 hit_way", hit_way, hw);
    chk("R5 cmd", ls_upd_cmd, cmd);
    chk("R6 ls_way", ls_upd_way, tw);
    chk("R6 cs_way", cs_wr_way, tw);
    chk("R7 ls_valid", ls_upd_valid, req_valid && ((act_update_priv && h) || act_write_data));
    chk("R8 cs_en", cs_wr_en, req_valid && act_next_stable && (h || act_write_data));
    chk("R8 cs_state", cs_wr_state, act_next_state);
    chk("R8 cs_set", cs_wr_set, req_set);
    chk("R9 mshr_en", mshr_upd_en,
        req_valid && (act_mshr_alloc || act_mshr_update || act_mshr_dealloc || rp));
    chk("R9 mshr_idx", mshr_upd_idx, mshr_hit ? mshr_hit_idx : mshr_free_idx);
    chk("R4 wait_evict", mshr_wait_evict, rp);
    chk("R10 entry_addr", mshr_entry_addr,
        rp ? {tg[lru_way], req_set, 4'h0} : {req_tag, req_set, 4'h0});
    chk("R10 entry_state", mshr_entry_state, rp ? st[lru_way] : act_next_state);
    chk("R11 snoop_valid", snoop_valid, req_valid && act_send_data);
    chk("R11 snoop_set", snoop_set, req_set);
    chk("R11 snoop_way", snoop_way, hw);
  endtask

  task automatic clear();
    req_valid = 1; act_write_data = 0; act_update_priv = 0; act_next_stable = 0;
    act_send_data = 0; act_mshr_alloc = 0; act_mshr_update = 0; act_mshr_dealloc = 0;
    mshr_hit = 0; mshr_hit_idx = 2'd1; mshr_free_idx = 2'd3;
    tg[0] = 8'h11; tg[1] = 8'h22; tg[2] = 8'h33; tg[3] = 8'h44;
    st[0] = 3'd1; st[1] = 3'd2; st[2] = 3'd3; st[3] = 3'd4;
    way_can_read = 4'hF; way_can_write = 4'h0; lru_way = 2'd1;
    req_set = 4'h5; act_next_state = 3'd6;
  endtask

  task automatic t_reset();
    chk("R2 reset ls_valid", ls_upd_valid, 0);
    chk("R2 reset cs_en", cs_wr_en, 0);
    chk("R2 reset mshr_en", mshr_upd_en, 0);
    chk("R2 reset snoop", snoop_valid, 0);
    chk("R2 reset addr", mshr_entry_addr, 0);
  endtask

  task automatic t_hit_priv();
    clear(); req_tag = 8'h33; act_update_priv = 1; act_next_stable = 1; step();
  endtask

  task automatic t_replace();
    clear(); req_tag = 8'h99; act_write_data = 1; act_mshr_alloc = 1; lru_way = 2'd3; step();
  endtask

  task automatic t_replace_only();
    clear(); req_tag = 8'h98; act_write_data = 1; way_can_write = 4'h4;
    way_can_read = 4'h0; lru_way = 2'd2; step();
  endtask

  task automatic t_no_victim();
    clear(); req_tag = 8'h77; act_write_data = 1; act_next_stable = 1;
    way_can_read = 4'hD; lru_way = 2'd1; step();
  endtask

  task automatic t_hit_write();
    clear(); req_tag = 8'h44; act_write_data = 1; act_next_stable = 1; lru_way = 2'd0; step();
  endtask

  task automatic t_unstable_mshr();
    clear(); req_tag = 8'h22; act_update_priv = 1; act_mshr_update = 1;
    mshr_hit = 1; mshr_hit_idx = 2'd2; step();
    clear(); req_tag = 8'h22; act_mshr_dealloc = 1; act_next_stable = 1; mshr_hit = 0; step();
  endtask

  task automatic t_no_priv_match();
    clear(); req_tag = 8'h11; way_can_read = 4'hE; act_update_priv = 1;
    act_next_stable = 1; lru_way = 2'd2; step();
  endtask

  task automatic t_snoop();
    clear(); req_tag = 8'h22; act_send_data = 1; req_set = 4'hA; step();
  endtask

  task automatic t_idle();
    clear(); req_valid = 0; req_tag = 8'h55; act_write_data = 1; act_update_priv = 1;
    act_next_stable = 1; act_send_data = 1; act_mshr_alloc = 1; step();
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    clear(); req_valid = 0;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    t_reset();
    t_hit_priv();
    t_replace();
    t_replace_only();
    t_no_victim();
    t_hit_write();
    t_unstable_mshr();
    t_no_priv_match();
    t_snoop();
    t_idle();
    t_replace();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule